// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer placed on a simple register bus. Software sets a 16-bit reload value, picks a count rate and starts the timer. The count rate comes from two dividing stages in series: an 8-bit programmable prescaler, then a fixed power-of-two divider chosen from four settings. The live counter steps down once for each output tick of that chain.

If software fails to rewrite the live counter before it runs out, the counter expires. Expiry reloads the counter from the reload register. Depending on the enables, expiry also latches an interrupt flag, sends a one-cycle reset request, or does both. The interrupt flag stays set until software writes any value to a dedicated write-only clear location.

The bus is a single-cycle strobe. A write takes effect at the clock edge where `bus_valid` and `bus_write` are both high. Read data is combinational from the word address and does not depend on `bus_valid`.

Top module: `wdt_prescaled`

## Requirements
- R1: After reset the control word reads 0x0000, the reload and live count registers read 0xFFFF, and both `irq_o` and `rst_req_o` are low.
- R2: Registers are selected by `bus_addr[3:2]`: 0x0 control, 0x4 reload, 0x8 live count, 0xC interrupt clear. In the control word, bit 0 is the reset-request enable, bit 2 the interrupt enable, bits [4:3] the divider select, bit 5 the run enable and bits [15:8] the prescale value P. All other control bits read 0. The clear location always reads 0.
- R3: While the run bit is 1, a count tick occurs once every (P+1)·2^(4+S) clock cycles, where S is the divider select (00→16, 01→32, 10→64, 11→128). The tick chain restarts from zero whenever the run bit is 0.
- R4: On each tick a nonzero live count decreases by one. A tick that finds the count at 0 is an expiry, and it reloads the count from the reload register as it stood before that edge.
- R5: While the run bit is 0, the live count holds its value and no expiry occurs.
- R6: A write to 0x8 loads bits [15:0] into the live count at that edge. This write takes priority over a tick in the same cycle and is the keepalive.
- R7: An expiry while the interrupt enable is 1 sets `irq_o`, which stays high until a clear write.
- R8: A write of any data to 0xC clears `irq_o` at that edge. If an interrupting expiry occurs in the same cycle, the flag stays set.
- R9: An expiry while the reset enable is 1 drives `rst_req_o` high for exactly the one cycle after the expiry edge. With the enable at 0, no pulse is produced.
- R10: A write to the reload register does not change the live count; the new value is used only at the next expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address; bits [3:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | 1 | Sticky expiry interrupt |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The assertions rely on one property of the inputs: expiries are at least sixteen cycles apart, because the shortest tick period is sixteen cycles. The reset pulse check and the one-step-per-cycle count check both depend on this. The stimulus changes the prescale and divider fields only while the run bit is off, or rewrites them with the same values, so the period of the tick chain stays well defined. Keepalive, reload and clear writes are issued at arbitrary times with respect to the tick phase.

// File: rtl/wdt_prescaled.sv
module wdt_prescaled #(
  parameter int DW      = 32,
  parameter int AW      = 4,
  parameter int CW      = 16,
  parameter int PW      = 8,
  parameter int SW      = 2,
  parameter int DIV_LOG = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_o,
  output logic          rst_req_o
);

  localparam int DIVW   = DIV_LOG + (1 << SW) - 1;
  localparam int B_RST  = 0;
  localparam int B_IRQ  = 2;
  localparam int B_SEL  = 3;
  localparam int B_RUN  = 5;
  localparam int B_PRE  = 8;
  localparam logic [1:0] A_CTL = 2'd0;
  localparam logic [1:0] A_RLD = 2'd1;
  localparam logic [1:0] A_CNT = 2'd2;
  localparam logic [1:0] A_CLR = 2'd3;

  logic [PW-1:0]   pre_q;
  logic [SW-1:0]   sel_q;
  logic            run_q, irqen_q, rsten_q;
  logic [CW-1:0]   rld_q, cnt_q;
  logic [PW-1:0]   pre_cnt;
  logic [DIVW-1:0] div_cnt, div_last;
  logic            irq_q, rstp_q;

  logic [1:0] idx;
  logic       wr, wr_ctl, wr_rld, wr_cnt, wr_clr;
  logic       pre_hit, tick, expire;

  assign idx    = bus_addr[3:2];
  assign wr     = bus_valid & bus_write;
  assign wr_ctl = wr & (idx == A_CTL);
  assign wr_rld = wr & (idx == A_RLD);
  assign wr_cnt = wr & (idx == A_CNT);
  assign wr_clr = wr & (idx == A_CLR);

  always_comb begin
    div_last = '0;
    for (int i = 0; i < (1 << SW); i++)
      if (sel_q == SW'(i)) div_last = DIVW'((1 << (DIV_LOG + i)) - 1);
  end

  assign pre_hit = run_q & (pre_cnt >= pre_q);
  assign tick    = pre_hit & (div_cnt >= div_last);
  assign expire  = tick & (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      sel_q   <= '0;
      run_q   <= 1'b0;
      irqen_q <= 1'b0;
      rsten_q <= 1'b0;
    end else if (wr_ctl) begin
      pre_q   <= bus_wdata[B_PRE +: PW];
      sel_q   <= bus_wdata[B_SEL +: SW];
      run_q   <= bus_wdata[B_RUN];
      irqen_q <= bus_wdata[B_IRQ];
      rsten_q <= bus_wdata[B_RST];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (!run_q) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (pre_hit) begin
      pre_cnt <= '0;
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_q <= '1;
      cnt_q <= '1;
    end else begin
      if (wr_rld) rld_q <= bus_wdata[CW-1:0];
      if (wr_cnt)      cnt_q <= bus_wdata[CW-1:0];
      else if (expire) cnt_q <= rld_q;
      else if (tick)   cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      rstp_q <= 1'b0;
    end else begin
      rstp_q <= expire & rsten_q;
      if (expire & irqen_q) irq_q <= 1'b1;
      else if (wr_clr)      irq_q <= 1'b0;
    end
  end

  assign irq_o     = irq_q;
  assign rst_req_o = rstp_q;

  always_comb begin
    bus_rdata = '0;
    case (idx)
      A_CTL: begin
        bus_rdata[B_PRE +: PW] = pre_q;
        bus_rdata[B_SEL +: SW] = sel_q;
        bus_rdata[B_RUN]       = run_q;
        bus_rdata[B_IRQ]       = irqen_q;
        bus_rdata[B_RST]       = rsten_q;
      end
      A_RLD:   bus_rdata[CW-1:0] = rld_q;
      A_CNT:   bus_rdata[CW-1:0] = cnt_q;
      default: bus_rdata = '0;
    endcase
  end

  p_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_cnt) |=> $stable(cnt_q));

  p_keepalive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt_q == $past(bus_wdata[CW-1:0])));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt && cnt_q != '0) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1));

  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !wr_clr) |=> irq_o);

  p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(irqen_q));

  p_rst_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);

  p_rst_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> $past(rsten_q));

  p_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !run_q) |=> !irq_o);

endmodule

// File: tb/wdt_prescaled_tb.sv
module wdt_prescaled_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, rst_req_o;

  wdt_prescaled dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  always #2.5 clk = ~clk;

  int    vectors = 0;
  int    errors  = 0;
  int    cycles  = 0;
  string cur_req = "R1";
  bit    done    = 0;

  logic [31:0] m_ctl;
  logic [15:0] m_rld, m_cnt;
  logic        m_irq, m_rstp;
  int          m_acc;

  task automatic fail(input string what, input logic [31:0] act, input logic [31:0] exp);
    errors++;
    $display("FAIL %s %s actual=0x%0h expected=0x%0h at cycle %0d", cur_req, what, act, exp, cycles);
  endtask

  always @(posedge clk) begin
    logic [31:0] exp_rd;
    int period;
    bit tk, ex, wctl, wrld, wcnt, wclr;
    cycles++;
    if (!rst_n) begin
      m_ctl = 0; m_rld = 16'hFFFF; m_cnt = 16'hFFFF; m_irq = 0; m_rstp = 0; m_acc = 0;
    end else begin
      wctl = bus_valid && bus_write && bus_addr[3:2] == 2'd0;
      wrld = bus_valid && bus_write && bus_addr[3:2] == 2'd1;
      wcnt = bus_valid && bus_write && bus_addr[3:2] == 2'd2;
      wclr = bus_valid && bus_write && bus_addr[3:2] == 2'd3;
      period = (int'(m_ctl[15:8]) + 1) * (16 << m_ctl[4:3]);
      tk = 0;
      if (m_ctl[5]) begin
        if (m_acc == period - 1) begin tk = 1; m_acc = 0; end
        else m_acc++;
      end else m_acc = 0;
      ex = tk && (m_cnt == 0);
      m_rstp = ex && m_ctl[0];
      if (ex && m_ctl[2]) m_irq = 1;
      else if (wclr) m_irq = 0;
      if (wcnt) m_cnt = bus_wdata[15:0];
      else if (tk) m_cnt = (m_cnt == 0) ? m_rld : m_cnt - 16'd1;
      if (wrld) m_rld = bus_wdata[15:0];
      if (wctl) m_ctl = bus_wdata & 32'h0000_FF3D;
    end
    #1;
    case (bus_addr[3:2])
      2'd0: exp_rd = m_ctl;
      2'd1: exp_rd = {16'h0, m_rld};
      2'd2: exp_rd = {16'h0, m_cnt};
      default: exp_rd = 0;
    endcase
    vectors++;
    if (bus_rdata !== exp_rd) fail("rdata", bus_rdata, exp_rd);
    if (irq_o !== m_irq) fail("irq_o", {31'h0, irq_o}, {31'h0, m_irq});
    if (rst_req_o !== m_rstp) fail("rst_req_o", {31'h0, rst_req_o}, {31'h0, m_rstp});
    if (cycles == 150000 && !done) begin
      errors++;
      $display("FAIL watchdog expired during %s", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [3:0] a);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cur_req = "R1";
    idle(3);
    rst_n = 1;
    for (int a = 0; a < 16; a += 4) rd(4'(a));

    cur_req = "R2";
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0);
    wr(4'h0, 32'h0);
    rd(4'hC);
    wr(4'hC, 32'h5);
    rd(4'h4);

    cur_req = "R5";
    wr(4'h4, 32'h3);
    wr(4'h8, 32'h3);
    bus_addr = 4'h8;
    idle(100);

    cur_req = "R3";
    wr(4'h0, 32'h0000_0129);
    bus_addr = 4'h8;
    idle(200);
    cur_req = "R9";
    idle(400);
    cur_req = "R4";
    wr(4'h0, 32'h0);
    bus_addr = 4'h8;
    idle(20);

    cur_req = "R7";
    wr(4'h0, 32'h0000_0024);
    bus_addr = 4'h8;
    idle(150);
    cur_req = "R8";
    wr(4'hC, 32'h0);
    idle(70);
    for (int k = 0; k < 20; k++) begin
      wr(4'hC, 32'(k));
      idle(k + 3);
    end

    cur_req = "R6";
    wr(4'h0, 32'h0000_0025);
    for (int k = 0; k < 20; k++) begin
      wr(4'h8, 32'h3);
      bus_addr = 4'h8;
      idle(40);
    end

    cur_req = "R10";
    wr(4'h4, 32'h7);
    bus_addr = 4'h8;
    idle(300);
    wr(4'hC, 32'h1);
    cur_req = "R5";
    wr(4'h0, 32'h0000_0004);
    bus_addr = 4'h8;
    idle(60);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule